// File: doc/BRIEF.md
# Multi-level symbol capture and signature compaction

This block sits on the device side of a multi-level test link, just after the on-chip converter that turns each received voltage level back into an R-bit word. While a test application window is open, every decoded word that the converter marks valid is sent out on R parallel scan-chain inputs, one bit per chain. In the same cycle the word is folded into a 32-bit multiple-input signature register.

When the tester closes the window, the register holds a signature of the stimulus exactly as it was received. The block compares this signature with an expected value that the tester supplies. A mismatch means at least one symbol was decoded wrongly on the noisy link, so the tester can repeat the application.

The word width R is a parameter with a legal range of 2 to 8, and the number of scan outputs equals R. The default is 6.

Top module: `sym_capture_misr`

## Requirements
- R1: While `rst_n` is low, and after it is released, `signature` is 0, `check_done` is 0, `sig_match` is 0 and `scan_shift` is 0.
- R2: In the cycle after `app_start` is sampled high, `signature` is 0, `check_done` is 0 and `sig_match` is 0, and an application window is open.
- R3: A word is accepted when `sym_valid` is high, a window is open and `app_start` is low. In the cycle after acceptance, `scan_shift` is 1 and `scan_bits[i]` equals bit i of the word. In every other cycle `scan_shift` is 0 and `scan_bits` holds its previous value.
- R4: On an accepted word, with S the current signature, the new signature is (S shifted left by one with 0 entering bit 0), XOR 0x00400007 when bit 31 of S is 1 (polynomial x^32+x^22+x^2+x+1), XOR the word zero-extended into the low R bits.
- R5: In a cycle where no word is accepted and `app_start` is low, `signature` keeps its value. This includes every cycle outside a window.
- R6: When `app_end` is high during an open window, a word accepted in that same cycle is still folded in. The window then closes, and later valid words neither change `signature` nor pulse `scan_shift`.
- R7: One cycle after `app_end` is sampled in an open window, `check_done` is 1 and `sig_match` is 1 exactly when the final signature equals `exp_sig`. Both keep their values, whatever `exp_sig` does, until the next `app_start`.
- R8: When `app_start` and `sym_valid` are high in the same cycle, `app_start` wins. The word is not folded in and `scan_shift` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_word | input | SYM_W | Decoded word from the converter |
| sym_valid | input | 1 | Word on `sym_word` is valid |
| app_start | input | 1 | Opens an application window and clears the signature |
| app_end | input | 1 | Closes the window and triggers the comparison |
| exp_sig | input | SIG_W | Expected signature from the tester |
| scan_bits | output | SYM_W | One bit per scan-chain input |
| scan_shift | output | 1 | Shift enable for the scan chains |
| signature | output | SIG_W | Signature register contents |
| check_done | output | 1 | Comparison result is valid |
| sig_match | output | 1 | Final signature equals `exp_sig` |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the last valid word and the end strobe. The bench raises both together and expects the comparison to include that final word, so it checks the match result against a signature modelled with the word included. The second pair is a start strobe and a valid word. The bench raises both together and checks that the signature reads zero and that no shift pulse appears.

// File: rtl/sym_capture_misr.sv
module sym_capture_misr #(
  parameter int SYM_W = 6,
  parameter int SIG_W = 32,
  parameter logic [SIG_W-1:0] POLY = 32'h0040_0007
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym_word,
  input  logic             sym_valid,
  input  logic             app_start,
  input  logic             app_end,
  input  logic [SIG_W-1:0] exp_sig,
  output logic [SYM_W-1:0] scan_bits,
  output logic             scan_shift,
  output logic [SIG_W-1:0] signature,
  output logic             check_done,
  output logic             sig_match
);
  localparam int PAD = SIG_W - SYM_W;

  logic             active;
  logic             take;
  logic [SIG_W-1:0] sig_nxt;
  logic [SIG_W-1:0] sig_final;

  assign take      = sym_valid && active && !app_start;
  assign sig_nxt   = {signature[SIG_W-2:0], 1'b0}
                   ^ (signature[SIG_W-1] ? POLY : '0)
                   ^ {{PAD{1'b0}}, sym_word};
  assign sig_final = take ? sig_nxt : signature;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      signature  <= '0;
      active     <= 1'b0;
      check_done <= 1'b0;
      sig_match  <= 1'b0;
      scan_shift <= 1'b0;
      scan_bits  <= '0;
    end else begin
      if (app_start) begin
        signature  <= '0;
        active     <= 1'b1;
        check_done <= 1'b0;
        sig_match  <= 1'b0;
      end else begin
        signature <= sig_final;
        if (app_end && active) begin
          active     <= 1'b0;
          check_done <= 1'b1;
          sig_match  <= (sig_final == exp_sig);
        end
      end
      scan_shift <= take;
      if (take) scan_bits <= sym_word;
    end
  end
endmodule

module sym_capture_misr_chk #(
  parameter int SIG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sym_valid,
  input logic             app_start,
  input logic             app_end,
  input logic             active,
  input logic [SIG_W-1:0] signature,
  input logic             check_done,
  input logic             sig_match,
  input logic             scan_shift
);
  // R2
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    app_start |=> (signature == '0 && !check_done && !sig_match));

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_valid && !app_start) |=> $stable(signature));

  // R3
  shift_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_shift |-> ($past(sym_valid) && !$past(app_start)));

  // R7
  done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (app_end && active && !app_start) |=> check_done);

  // R7
  match_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (check_done && !app_start) |=> (check_done && $stable(sig_match)));
endmodule

bind sym_capture_misr sym_capture_misr_chk #(.SIG_W(SIG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .app_start(app_start),
  .app_end(app_end), .active(active), .signature(signature),
  .check_done(check_done), .sig_match(sig_match), .scan_shift(scan_shift)
);

// File: tb/sim_sym_capture_misr.sv
module sim_sym_capture_misr;
  localparam int W = 6;
  localparam logic [31:0] POLY = 32'h0040_0007;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] sym_word = '0;
  logic sym_valid = 1'b0, app_start = 1'b0, app_end = 1'b0;
  logic [31:0] exp_sig = '0;
  logic [W-1:0] scan_bits;
  logic scan_shift, check_done, sig_match;
  logic [31:0] signature;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_sig;

  always #5 clk = ~clk;

  sym_capture_misr #(.SYM_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .sym_word(sym_word), .sym_valid(sym_valid),
    .app_start(app_start), .app_end(app_end), .exp_sig(exp_sig),
    .scan_bits(scan_bits), .scan_shift(scan_shift), .signature(signature),
    .check_done(check_done), .sig_match(sig_match));

  function automatic logic [31:0] fold(input logic [31:0] s, input logic [W-1:0] w);
    return {s[30:0], 1'b0} ^ (s[31] ? POLY : 32'h0) ^ {{(32-W){1'b0}}, w};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] w, input logic s, input logic e);
    sym_valid = v; sym_word = w; app_start = s; app_end = e;
    @(negedge clk);
    sym_valid = 1'b0; app_start = 1'b0; app_end = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(1, 6'h3f, 0, 0);
    step(0, 0, 0, 0);
    check("R1 sig", signature, 0);
    check("R1 done/match/shift", {check_done, sig_match, scan_shift}, 0);
    rst_n = 1'b1;
    step(1, 6'h15, 0, 0);
    check("R1 idle sig", signature, 0);
    check("R1 idle shift", scan_shift, 0);
  endtask

  task automatic t_basic(input int n, input int seed, input logic good);
    m_sig = 0;
    step(0, 0, 1, 0);
    check("R2 sig clear", signature, 0);
    check("R2 done clear", {check_done, sig_match}, 0);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] w;
      w = W'((i * 37 + seed) ^ (i >> 2));
      m_sig = fold(m_sig, w);
      step(1, w, 0, 0);
      check("R4 sig", signature, m_sig);
      check("R3 shift", scan_shift, 1);
      check("R3 bits", 32'(scan_bits), 32'(w));
      if (i % 3 == 1) begin
        step(0, 6'h2a, 0, 0);
        check("R5 hold", signature, m_sig);
        check("R3 no shift", scan_shift, 0);
        check("R3 bits hold", 32'(scan_bits), 32'(w));
      end
    end
    exp_sig = good ? m_sig : (m_sig ^ 32'h0000_0100);
    step(0, 0, 0, 1);
    check("R7 done", check_done, 1);
    check("R7 match", sig_match, good);
  endtask

  task automatic t_end_with_word;
    m_sig = 0;
    step(0, 0, 1, 0);
    step(1, 6'h21, 0, 0); m_sig = fold(m_sig, 6'h21);
    step(1, 6'h0c, 0, 0); m_sig = fold(m_sig, 6'h0c);
    m_sig = fold(m_sig, 6'h37);
    exp_sig = m_sig;
    step(1, 6'h37, 0, 1);
    check("R6 final word folded", signature, m_sig);
    check("R6 match incl final", {check_done, sig_match}, 2'b11);
    step(1, 6'h11, 0, 0);
    check("R6 closed sig", signature, m_sig);
    check("R6 closed shift", scan_shift, 0);
    exp_sig = ~m_sig;
    step(1, 6'h05, 0, 0);
    check("R7 stable after exp change", {check_done, sig_match}, 2'b11);
  endtask

  task automatic t_start_collision;
    step(1, 6'h3c, 1, 0);
    check("R8 word dropped", signature, 0);
    check("R8 no shift", scan_shift, 0);
    check("R2 done cleared", check_done, 0);
    step(1, 6'h01, 0, 0);
    check("R4 first after start", signature, fold(0, 6'h01));
    exp_sig = 32'hdead_beef;
    step(0, 0, 0, 1);
    check("R7 mismatch", {check_done, sig_match}, 2'b10);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic(8, 5, 1);
    t_basic(20, 51, 0);
    t_basic(40, 13, 1);
    t_end_with_word();
    t_start_collision();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule